// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor Core

This block is a small single-address processor built around one accumulator. Each instruction is one 16-bit memory word: the upper four bits select the operation and the lower twelve bits name a memory word. The core fetches a word from the address held in its program counter. The word goes into a buffer register and then into an instruction register. The core decodes it, then reads an operand into the same buffer register or writes the accumulator back to memory. Three operations exist: load the accumulator, add to the accumulator, and store the accumulator. Any other operation code stops the core until the next reset.

The core drives a synchronous, word-addressed memory through an address port, a write-data port, a write strobe and a read-data port. Read data appears one clock after the address. The core does not stall, so it needs a memory with exactly that latency. The accumulator, the carry flag from the last addition and a halt flag are visible at the ports. The reset input is asynchronous and active low. The core takes that input through a two-stage synchronizer, so the assertion of reset acts at once and its release is aligned to the clock.

Top module: `acc_core`

## Requirements
- R1: While reset is asserted, the accumulator, the carry flag, the halt flag and the write strobe are 0, and the first fetch after reset reads address 0.
- R2: Bits 15:12 of an instruction word are the operation code and bits 11:0 are the operand address. Instructions run in address order: the program counter steps by exactly one per fetch.
- R3: Operation code 0000 copies the addressed memory word into the accumulator and leaves the carry flag unchanged.
- R4: Operation code 1000 sets the accumulator to the accumulator plus the addressed word, modulo 2^16. The carry flag takes the carry out of bit 15, and the flag changes only on an addition.
- R5: Operation code 0001 raises the write strobe for exactly one cycle, with the operand address on the address port and the accumulator on the write-data port. No other operation writes memory.
- R6: Any other operation code sets the halt flag. The flag stays set until reset. While it is set, no write occurs and the accumulator holds its value.
- R7: Load and add each take 8 clock cycles, store takes 6, and an unknown code reaches the halt flag 5 cycles after its fetch begins. This assumes read data that arrives one cycle after the address.
- R8: The first fetch starts on the third rising clock edge after the reset input is released. Two of those edges are spent in the reset synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 12 | Memory word address |
| mem_wdata | output | 16 | Data to write (the accumulator) |
| mem_we | output | 1 | Write strobe, one cycle per store |
| mem_rdata | input | 16 | Read data, valid one cycle after the address |
| acc | output | 16 | Accumulator |
| carry | output | 1 | Carry out of the most recent addition |
| halted | output | 1 | Set after an unknown operation code |

## Verification
The embedded properties assume a memory that returns a word exactly one clock after the address. They also assume that reset is the only way out of the halted state. Those properties cover the single-cycle write strobe, the unit step of the program counter, the carry flag moving only on additions and the stickiness of the halt. The bench provides its own memory model with one cycle of read latency. It writes program and data words only while reset is held. It raises reset only on a falling clock edge, so the synchronizer sees a clean release. Every program ends in an unknown code, so each run finishes in the halted state that the properties describe.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_LOAD  = 4'b0000;
  localparam logic [OPC_W-1:0] OPC_ADD   = 4'b1000;
  localparam logic [OPC_W-1:0] OPC_STORE = 4'b0001;

  typedef enum logic [3:0] {
    S_F_ADDR  = 4'd0,  // MAR <= PC
    S_F_WAIT  = 4'd1,  // memory reads MAR, PC steps
    S_F_CAP   = 4'd2,  // MBR <= read data
    S_F_IR    = 4'd3,  // IR <= MBR
    S_DECODE  = 4'd4,  // MAR <= operand address or halt
    S_OP_WAIT = 4'd5,  // memory reads operand
    S_OP_CAP  = 4'd6,  // MBR <= operand
    S_EXEC    = 4'd7,  // ACC update
    S_WRITE   = 4'd8,  // memory write of ACC
    S_STOP    = 4'd9   // halted
  } cpu_state_e;

endpackage

// File: rtl/acc_rst_sync.sv
module acc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_out = chain_q[STAGES-1];

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_core_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode,
  output logic             mar_en,
  output logic             mar_sel_ir,
  output logic             pc_inc,
  output logic             mbr_en,
  output logic             ir_en,
  output logic             acc_load,
  output logic             acc_add,
  output logic             mem_we,
  output logic             halted
);

  cpu_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_F_ADDR:  state_d = S_F_WAIT;
      S_F_WAIT:  state_d = S_F_CAP;
      S_F_CAP:   state_d = S_F_IR;
      S_F_IR:    state_d = S_DECODE;
      S_DECODE: begin
        if (opcode == OPC_LOAD || opcode == OPC_ADD) begin
          state_d = S_OP_WAIT;
        end else if (opcode == OPC_STORE) begin
          state_d = S_WRITE;
        end else begin
          state_d = S_STOP;
        end
      end
      S_OP_WAIT: state_d = S_OP_CAP;
      S_OP_CAP:  state_d = S_EXEC;
      S_EXEC:    state_d = S_F_ADDR;
      S_WRITE:   state_d = S_F_ADDR;
      S_STOP:    state_d = S_STOP;
      default:   state_d = S_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_F_ADDR;
    end else begin
      state_q <= state_d;
    end
  end

  always_comb begin
    mar_en     = 1'b0;
    mar_sel_ir = 1'b0;
    pc_inc     = 1'b0;
    mbr_en     = 1'b0;
    ir_en      = 1'b0;
    acc_load   = 1'b0;
    acc_add    = 1'b0;
    mem_we     = 1'b0;
    unique case (state_q)
      S_F_ADDR:  mar_en = 1'b1;
      S_F_WAIT:  pc_inc = 1'b1;
      S_F_CAP:   mbr_en = 1'b1;
      S_F_IR:    ir_en  = 1'b1;
      S_DECODE: begin
        mar_sel_ir = 1'b1;
        mar_en     = (opcode == OPC_LOAD) || (opcode == OPC_ADD) ||
                     (opcode == OPC_STORE);
      end
      S_OP_CAP:  mbr_en = 1'b1;
      S_EXEC: begin
        acc_load = (opcode == OPC_LOAD);
        acc_add  = (opcode == OPC_ADD);
      end
      S_WRITE:   mem_we = 1'b1;
      default: ;
    endcase
  end

  assign halted = (state_q == S_STOP);

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_STOP) |=> (state_q == S_STOP)); // R6

  AST_WRITE_AFTER_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WRITE) |-> ($past(state_q) == S_DECODE)); // R5

endmodule

// File: rtl/acc_adder.sv
module acc_adder #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  logic [WIDTH:0] c;

  assign c[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign sum[i]  = a[i] ^ b[i] ^ c[i];
    assign c[i+1]  = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
  end

  assign cout = c[WIDTH];

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mar_en,
  input  logic              mar_sel_ir,
  input  logic              pc_inc,
  input  logic              mbr_en,
  input  logic              ir_en,
  input  logic              acc_load,
  input  logic              acc_add,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-ADDR_W-1:0] opcode,
  output logic [DATA_W-1:0] acc,
  output logic              carry
);

  localparam int OPC_BITS = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [ADDR_W-1:0] mar_q, mar_d;
  logic [DATA_W-1:0] mbr_q, mbr_d;
  logic [DATA_W-1:0] ir_q, ir_d;
  logic [DATA_W-1:0] acc_q, acc_d;
  logic              cy_q, cy_d;
  logic [DATA_W-1:0] sum;
  logic              sum_cout;

  acc_adder #(.WIDTH(DATA_W)) u_add (
    .a    (acc_q),
    .b    (mbr_q),
    .sum  (sum),
    .cout (sum_cout)
  );

  always_comb begin
    pc_d  = pc_inc ? (pc_q + 1'b1) : pc_q;
    mar_d = mar_q;
    if (mar_en) begin
      mar_d = mar_sel_ir ? ir_q[ADDR_W-1:0] : pc_q;
    end
    mbr_d = mbr_en ? mem_rdata : mbr_q;
    ir_d  = ir_en ? mbr_q : ir_q;
    acc_d = acc_q;
    cy_d  = cy_q;
    if (acc_load) begin
      acc_d = mbr_q;
    end else if (acc_add) begin
      acc_d = sum;
      cy_d  = sum_cout;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      mar_q <= '0;
      mbr_q <= '0;
      ir_q  <= '0;
      acc_q <= '0;
      cy_q  <= 1'b0;
    end else begin
      pc_q  <= pc_d;
      mar_q <= mar_d;
      mbr_q <= mbr_d;
      ir_q  <= ir_d;
      acc_q <= acc_d;
      cy_q  <= cy_d;
    end
  end

  assign mem_addr  = mar_q;
  assign mem_wdata = acc_q;
  assign opcode    = ir_q[DATA_W-1:DATA_W-OPC_BITS];
  assign acc       = acc_q;
  assign carry     = cy_q;

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pc_q) |-> (pc_q == $past(pc_q) + 1'b1)); // R2

  AST_CARRY_ONLY_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cy_q) |-> $past(acc_add)); // R4

endmodule

// File: rtl/acc_core.sv
module acc_core #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] acc,
  output logic              carry,
  output logic              halted
);

  localparam int OPC_BITS = DATA_W - ADDR_W;

  logic                rst_int_n;
  logic                mar_en, mar_sel_ir, pc_inc, mbr_en, ir_en;
  logic                acc_load, acc_add;
  logic [OPC_BITS-1:0] opcode;

  acc_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_int_n)
  );

  acc_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .opcode     (opcode),
    .mar_en     (mar_en),
    .mar_sel_ir (mar_sel_ir),
    .pc_inc     (pc_inc),
    .mbr_en     (mbr_en),
    .ir_en      (ir_en),
    .acc_load   (acc_load),
    .acc_add    (acc_add),
    .mem_we     (mem_we),
    .halted     (halted)
  );

  acc_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .mar_en     (mar_en),
    .mar_sel_ir (mar_sel_ir),
    .pc_inc     (pc_inc),
    .mbr_en     (mbr_en),
    .ir_en      (ir_en),
    .acc_load   (acc_load),
    .acc_add    (acc_add),
    .mem_rdata  (mem_rdata),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .opcode     (opcode),
    .acc        (acc),
    .carry      (carry)
  );

  AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_we |=> !mem_we); // R5

  AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_int_n)
    halted |-> !mem_we); // R6

  AST_HALT_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    halted |=> $stable(acc)); // R6

endmodule

// File: tb/sim_acc_core.sv
module sim_acc_core;

  logic        clk;
  logic        rst_n;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic [15:0] mem_rdata;
  logic [15:0] acc;
  logic        carry;
  logic        halted;

  int n_chk;
  int n_fail;
  int cyc_total;

  // Sparse memory model: 0x000-0x01F and 0xFE0-0xFFF, one-cycle read latency
  logic [15:0] mem [64];

  function automatic int idx(input logic [11:0] a);
    return int'({a[11], a[4:0]});
  endfunction

  function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] a);
    return {op, a};
  endfunction

  acc_core u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_rdata (mem_rdata),
    .acc       (acc),
    .carry     (carry),
    .halted    (halted)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (mem_we) mem[idx(mem_addr)] <= mem_wdata;
    mem_rdata <= mem[idx(mem_addr)];
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 64; i++) mem[i] = 16'hF000;
  endtask

  task automatic run_prog(output int cyc, output int wr);
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    wr = 0;
    while (cyc < 200) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (mem_we) wr++;
      if (halted) break;
    end
  endtask

  // {a, b, sum, carry}
  localparam logic [48:0] VEC [5] = '{
    {16'h0003, 16'h0004, 16'h0007, 1'b0},
    {16'hFFFF, 16'h0001, 16'h0000, 1'b1},
    {16'h8000, 16'h8000, 16'h0000, 1'b1},
    {16'h1234, 16'h4321, 16'h5555, 1'b0},
    {16'hFFFF, 16'hFFFF, 16'hFFFE, 1'b1}
  };

  initial begin
    cyc_total = 0;
    forever begin
      @(posedge clk);
      cyc_total++;
      if (cyc_total > 100000) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected < 100000", cyc_total);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    int cyc;
    int wr;
    n_chk = 0;
    n_fail = 0;
    rst_n = 1'b0;
    hold_reset();
    repeat (2) @(negedge clk);

    // R1: reset state
    check(acc == 16'h0, "R1 acc in reset", 32'(acc), 0);
    check({carry, halted, mem_we} == 3'b000, "R1 flags in reset",
          32'({carry, halted, mem_we}), 0);
    check(mem_addr == 12'h000, "R1 fetch address in reset", 32'(mem_addr), 0);

    // Vector table: load 0xFF0, add 0xFF1, store 0xFF2, unknown code
    foreach (VEC[k]) begin
      hold_reset();
      mem[idx(12'h000)] = ins(4'b0000, 12'hFF0);
      mem[idx(12'h001)] = ins(4'b1000, 12'hFF1);
      mem[idx(12'h002)] = ins(4'b0001, 12'hFF2);
      mem[idx(12'h003)] = 16'hF000;
      mem[idx(12'hFF0)] = VEC[k][48:33];
      mem[idx(12'hFF1)] = VEC[k][32:17];
      mem[idx(12'hFF2)] = 16'hDEAD;
      run_prog(cyc, wr);
      check(acc == VEC[k][16:1], "R4 accumulator sum", 32'(acc), 32'(VEC[k][16:1]));
      check(carry == VEC[k][0], "R4 carry out", 32'(carry), 32'(VEC[k][0]));
      check(mem[idx(12'hFF2)] == VEC[k][16:1], "R5 stored word",
            32'(mem[idx(12'hFF2)]), 32'(VEC[k][16:1]));
      check(wr == 1, "R5 write count", wr, 1);
      check(halted, "R6 halt after program", 32'(halted), 1);
      check(cyc == 29, "R7 R8 cycles to halt", cyc, 29);
    end

    // R1: asynchronous reset clears state at once
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(acc == 16'h0 && !carry && !halted, "R1 async clear",
          32'({acc, carry, halted}), 0);

    // R3: load leaves carry unchanged
    hold_reset();
    mem[idx(12'h000)] = ins(4'b0000, 12'hFF0);
    mem[idx(12'h001)] = ins(4'b1000, 12'hFF1);
    mem[idx(12'h002)] = ins(4'b0000, 12'hFF3);
    mem[idx(12'h003)] = 16'h7000;
    mem[idx(12'hFF0)] = 16'hFFFF;
    mem[idx(12'hFF1)] = 16'h0002;
    mem[idx(12'hFF3)] = 16'h00AA;
    run_prog(cyc, wr);
    check(acc == 16'h00AA, "R3 load value", 32'(acc), 32'h00AA);
    check(carry == 1'b1, "R3 carry kept across load", 32'(carry), 1);
    check(wr == 0, "R5 no write without store", wr, 0);
    check(cyc == 31, "R7 load/add timing", cyc, 31);

    // R2 R5: ordered stores of successive accumulator values
    hold_reset();
    mem[idx(12'h000)] = ins(4'b0000, 12'hFF0);
    mem[idx(12'h001)] = ins(4'b0001, 12'hFF4);
    mem[idx(12'h002)] = ins(4'b1000, 12'hFF0);
    mem[idx(12'h003)] = ins(4'b0001, 12'hFF5);
    mem[idx(12'h004)] = 16'h2123;
    mem[idx(12'hFF0)] = 16'h5A5A;
    run_prog(cyc, wr);
    check(mem[idx(12'hFF4)] == 16'h5A5A, "R2 first store",
          32'(mem[idx(12'hFF4)]), 32'h5A5A);
    check(mem[idx(12'hFF5)] == 16'hB4B4, "R2 second store",
          32'(mem[idx(12'hFF5)]), 32'hB4B4);
    check(wr == 2, "R5 two writes", wr, 2);
    check(cyc == 35, "R7 store timing", cyc, 35);
    check(mem[idx(12'hFF0)] == 16'h5A5A, "R5 operand untouched",
          32'(mem[idx(12'hFF0)]), 32'h5A5A);

    // R6: unknown code at address 0 halts and stays halted
    hold_reset();
    mem[idx(12'h000)] = 16'h7ABC;
    mem[idx(12'h001)] = ins(4'b0000, 12'hFF0);
    mem[idx(12'hFF0)] = 16'h1111;
    run_prog(cyc, wr);
    check(cyc == 7, "R6 R7 halt timing", cyc, 7);
    wr = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (mem_we) wr++;
    end
    check(halted, "R6 halt sticky", 32'(halted), 1);
    check(acc == 16'h0, "R6 acc held in halt", 32'(acc), 0);
    check(wr == 0, "R6 no write in halt", wr, 0);

    // R1: reset during a run restarts cleanly from address 0
    hold_reset();
    mem[idx(12'h000)] = ins(4'b0000, 12'hFF0);
    mem[idx(12'h001)] = 16'hF000;
    mem[idx(12'hFF0)] = 16'h0BAD;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(acc == 16'h0 && !halted, "R1 reset mid-run", 32'(acc), 0);
    run_prog(cyc, wr);
    check(acc == 16'h0BAD, "R3 load after restart", 32'(acc), 32'h0BAD);
    check(cyc == 15, "R8 restart timing", cyc, 15);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule